// File: doc/BRIEF.md
# Early-Terminating Radix-4 Sequential Multiplier

This block multiplies two 32-bit integers over several clock cycles. Each cycle it handles two multiplier bits. It uses radix-4 Booth recoding, so each cycle adds a partial product of 0, ±M or ±2M to a running sum. The block watches the part of the multiplier it has not yet consumed. When that remainder can no longer change the sum, the operation ends at once, so short multipliers cost few cycles. The result is the low 32 bits of the product, and this value is the same whether the operands are read as signed or unsigned.

An optional addend can be folded in. When accumulation is requested, the addend is the starting value of the running sum, which costs no extra cycle. A start strobe taken while the block is idle launches an operation. `busy_o` then stays high until the cycle in which the one-cycle `done_o` pulse appears together with the registered result.

Top module: `booth_seq_mul`

## Requirements
- R1: In the cycle after a synchronous reset, `busy_o`, `done_o` and `result_o` are all zero.
- R2: A start strobe seen while idle raises `busy_o` from the next cycle. `busy_o` stays high until it falls in the same cycle that `done_o` rises.
- R3: With accumulation off, `result_o` at the done pulse equals the low 32 bits of `mcand_i * mplier_i`. Signed and unsigned operand readings give the same value.
- R4: With accumulation on, `result_o` equals the low 32 bits of `mcand_i * mplier_i + addend_i`. With accumulation off, `addend_i` has no effect.
- R5: Let k be the smallest integer k ≥ 1 such that the multiplier, read as a signed 32-bit value, fits in a 2k-bit two's complement field. `done_o` is high exactly k clock edges after the edge that accepts the start.
- R6: A multiplier in the range -128..127 completes in at most 4 iteration cycles.
- R7: No operation takes more than 16 iteration cycles. A full-width multiplier such as 0x40000000 takes exactly 16.
- R8: `done_o` is high for exactly one cycle. `result_o` keeps its value until the next done pulse.
- R9: A start strobe that arrives while `busy_o` is high is ignored. The running operation keeps its operands and its cycle count, and no extra done pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch strobe, taken only when idle |
| acc_en_i | input | 1 | Add `addend_i` to the product |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier (sets the cycle count) |
| addend_i | input | 32 | Accumulate value |
| result_o | output | 32 | Low 32 bits of product (plus addend) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- the start and busy handshake;
- that `done_o` is a single-cycle pulse that closes a busy period;
- that the result holds between pulses;
- the cycle ceilings of 16 overall and 4 for 8-bit signed multipliers.

Only the bench scenarios can show the arithmetic itself and the exact data-dependent cycle count for a given multiplier width. The same holds for the effect of the addend, and for the fact that a start strobe during an operation leaves its operands and timing unchanged.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef enum logic [2:0] {
    BOP_ZERO = 3'd0,
    BOP_ADD1 = 3'd1,
    BOP_ADD2 = 3'd2,
    BOP_SUB1 = 3'd3,
    BOP_SUB2 = 3'd4
  } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_mul_pkg::*;
(
  input  logic [2:0] grp_i,
  output booth_op_e  op_o
);
  // grp_i = {bit i+1, bit i, bit i-1}
  always_comb begin
    unique case (grp_i)
      3'b001, 3'b010: op_o = BOP_ADD1;
      3'b011:         op_o = BOP_ADD2;
      3'b100:         op_o = BOP_SUB2;
      3'b101, 3'b110: op_o = BOP_SUB1;
      default:        op_o = BOP_ZERO;
    endcase
  end
endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  booth_op_e        op_i,
  input  logic [WIDTH-1:0] mcand_i,
  output logic [WIDTH-1:0] pp_o
);
  logic [WIDTH-1:0] dbl;
  assign dbl = {mcand_i[WIDTH-2:0], 1'b0};

  always_comb begin
    unique case (op_i)
      BOP_ADD1: pp_o = mcand_i;
      BOP_ADD2: pp_o = dbl;
      BOP_SUB1: pp_o = ~mcand_i + 1'b1;
      BOP_SUB2: pp_o = ~dbl + 1'b1;
      default:  pp_o = '0;
    endcase
  end
endmodule

// File: rtl/booth_exit_chk.sv
module booth_exit_chk #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] rem_i,
  input  logic             carry_i,
  output logic             spent_o
);
  // Remaining groups all recode to zero when the remainder is a pure
  // sign extension of the pending carry bit.
  logic all_zero, all_one;
  assign all_zero = (rem_i == '0);
  assign all_one  = (&rem_i);
  assign spent_o  = (all_zero && !carry_i) || (all_one && carry_i);
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             acc_en_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  input  logic [WIDTH-1:0] addend_i,
  output logic [WIDTH-1:0] result_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int STEPS = WIDTH / 2;
  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

  logic [WIDTH-1:0] acc_q, mcand_q, rem_q;
  logic             carry_q;
  logic [CNT_W-1:0] step_q;

  booth_op_e        op;
  logic [WIDTH-1:0] pp, acc_nxt, rem_nxt;
  logic             carry_nxt, spent, finish;

  booth_recode u_rec (
    .grp_i ({rem_q[1:0], carry_q}),
    .op_o  (op)
  );

  booth_ppgen #(.WIDTH(WIDTH)) u_pp (
    .op_i    (op),
    .mcand_i (mcand_q),
    .pp_o    (pp)
  );

  assign acc_nxt   = acc_q + pp;
  assign rem_nxt   = {{2{rem_q[WIDTH-1]}}, rem_q[WIDTH-1:2]};
  assign carry_nxt = rem_q[1];

  booth_exit_chk #(.WIDTH(WIDTH)) u_exit (
    .rem_i   (rem_nxt),
    .carry_i (carry_nxt),
    .spent_o (spent)
  );

  assign finish = spent || (step_q == LAST_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      rem_q    <= '0;
      carry_q  <= 1'b0;
      step_q   <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          acc_q   <= acc_en_i ? addend_i : '0;
          mcand_q <= mcand_i;
          rem_q   <= mplier_i;
          carry_q <= 1'b0;
          step_q  <= '0;
          busy_o  <= 1'b1;
        end
      end else begin
        acc_q   <= acc_nxt;
        mcand_q <= {mcand_q[WIDTH-3:0], 2'b00};
        rem_q   <= rem_nxt;
        carry_q <= carry_nxt;
        step_q  <= step_q + 1'b1;
        if (finish) begin
          busy_o   <= 1'b0;
          done_o   <= 1'b1;
          result_o <= acc_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [WIDTH-1:0] mplier_i,
  input logic [WIDTH-1:0] result_o,
  input logic             busy_o,
  input logic             done_o
);
  localparam int STEPS = WIDTH / 2;
  localparam int CW    = $clog2(STEPS + 2);

  logic [CW-1:0] ncyc;
  logic          short_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ncyc    <= '0;
      short_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      ncyc    <= '0;
      short_q <= (mplier_i[WIDTH-1:7] == '0) || (&mplier_i[WIDTH-1:7]);
    end else if (busy_o) begin
      ncyc <= ncyc + 1'b1;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> (done_o || $stable(result_o))); // R8
  AST_MAX_ITER: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ncyc <= CW'(STEPS))); // R7
  AST_SHORT_ITER: assert property (@(posedge clk) disable iff (rst)
    (done_o && short_q) |-> (ncyc <= CW'(4))); // R6
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .mplier_i (mplier_i),
  .result_o (result_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/sim_booth_seq_mul.sv
module sim_booth_seq_mul;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, acc_en_i = 1'b0;
  logic [31:0] mcand_i = '0, mplier_i = '0, addend_i = '0;
  logic [31:0] result_o;
  logic        busy_o, done_o;

  int checks = 0;
  int fails  = 0;
  bit wd_hit = 1'b0;

  always #4 clk = ~clk;

  booth_seq_mul u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .acc_en_i(acc_en_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i), .addend_i(addend_i),
    .result_o(result_o), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic int exp_cycles(input logic [31:0] m);
    for (int k = 1; k <= 16; k++) begin
      logic signed [31:0] sh;
      sh = $signed(m) >>> (2 * k - 1);
      if (sh == 0 || sh == -1) return k;
    end
    return 16;
  endfunction

  function automatic logic [31:0] exp_result(input logic [31:0] a, b, c,
                                             input logic en);
    logic [63:0] p;
    p = 64'(a) * 64'(b);
    return p[31:0] + (en ? c : 32'd0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Run one operation; optionally pulse a second start while busy (R9).
  task automatic run_op(input logic [31:0] a, b, c, input logic en,
                        input bit intrude);
    int cyc = 0;
    logic [31:0] er;
    er = exp_result(a, b, c, en);
    @(negedge clk);
    mcand_i = a; mplier_i = b; addend_i = c; acc_en_i = en; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", 32'(busy_o), 32'd1);
    if (intrude) begin
      mcand_i = ~a; mplier_i = 32'h7fff_ffff; addend_i = ~c; acc_en_i = ~en;
      start_i = 1'b1;
    end
    while (1) begin
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
      if (done_o || cyc > 40) break;
    end
    check(en ? "R4 accumulate result" : "R3 product result", result_o, er);
    check("R5 cycle count", 32'(cyc), 32'(exp_cycles(b)));
    check("R2 busy low at done", 32'(busy_o), 32'd0);
    if (b[31:7] == '0 || &b[31:7])
      check("R6 short multiplier <= 4", 32'(cyc <= 4), 32'd1);
    @(negedge clk);
    check("R8 done single pulse", 32'(done_o), 32'd0);
    check("R8 result held", result_o, er);
    if (intrude) begin
      repeat (3) begin
        @(negedge clk);
        check("R9 no extra done", 32'(done_o | busy_o), 32'd0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    wd_hit = 1'b1;
  end

  initial begin
    logic [31:0] a, b, c;
    int w;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset busy", 32'(busy_o), 32'd0);
    check("R1 reset done", 32'(done_o), 32'd0);
    check("R1 reset result", result_o, 32'd0);

    // directed corners
    run_op(32'd7, 32'd0, 32'd0, 1'b0, 0);                  // R5 k=1
    run_op(32'h1234_5678, 32'd127, 32'd0, 1'b0, 0);        // R6
    run_op(32'h1234_5678, 32'hffff_ff80, 32'd0, 1'b0, 0);  // R6 -128
    run_op(32'hdead_beef, 32'd128, 32'd0, 1'b0, 0);        // R5 k=5
    run_op(32'hffff_ffff, 32'hffff_ffff, 32'd0, 1'b0, 0);  // R3 signed -1
    run_op(32'h0000_0003, 32'h4000_0000, 32'd0, 1'b0, 0);  // R7 16 cycles
    run_op(32'h8000_0001, 32'h8000_0000, 32'd0, 1'b0, 0);  // R7 min neg
    run_op(32'd9, 32'd11, 32'h0000_1000, 1'b1, 0);         // R4 on
    run_op(32'd9, 32'd11, 32'hffff_ffff, 1'b0, 0);         // R4 addend ignored
    run_op(32'h0bad_cafe, 32'd300, 32'h5555_aaaa, 1'b1, 1); // R9 intrusion
    run_op(32'h0000_0005, 32'h0000_0006, 32'd0, 1'b0, 1);   // R9 short op

    // constrained random: multiplier width chosen to spread cycle counts
    for (int i = 0; i < 300 && !wd_hit; i++) begin
      a = $urandom();
      c = $urandom();
      w = 1 + ($urandom() % 32);
      b = $urandom();
      if (w < 32) begin
        b = b & ((32'd1 << w) - 1);
        if (b[w-1] && ($urandom() % 2 == 0)) b = b | ~((32'd1 << w) - 1);
      end
      run_op(a, b, c, 1'(($urandom() % 2)), (i % 17) == 0);
    end

    if (wd_hit) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule